// File: doc/BRIEF.md
# Half-Bridge Center-Aligned PWM Generator

This block drives the high-side and low-side gates of one half-bridge leg from a triangular up-down counter. Gate A turns on and off at two compare points while the counter rises, and gate B does the same while it falls. This gives two center-aligned pulses that do not overlap. Both gates are forced off each time the counter passes through zero.

Period, compare A and compare B are written into shadow registers. The three shadows move into the working set together, at one counter-zero boundary, and only once for each software arm. A frequency change therefore never reaches the gates as a mix of old and new values.

A latched trip, raised by a pin pulse or by a register command, holds both gates low until software clears it. The gates then resume at the next counter zero. A sync pulse reloads the counter with a phase value, and a zero marker goes out to neighbouring legs.

Register writes use a valid/ready port. `wr_ready` is held high, so the block never applies back-pressure, and every cycle with `wr_valid` high is one accepted write.

Top module: `halfbridge_pwm`

## Requirements
- R1: With an active period P > 0, the counter runs 0, 1, …, P, P-1, …, 1, 0, so there is one zero every 2P cycles. `sync_out` is high in each cycle the counter is zero, and stays high while the active period is 0.
- R2: `pwm_a` rises in the cycle after an up-count cycle whose count equals compare A. It falls in the cycle after an up-count cycle whose count equals compare B. `pwm_b` rises after a down-count match on compare B and falls after a down-count match on compare A. With compare A < compare B ≤ P, each gate is high for (compare B − compare A) cycles per period.
- R3: A zero cycle forces both gates low from the next cycle. The gates are never high together. A turn-on is suppressed while the other gate is high, including when compare A ≥ compare B or compare B > P.
- R4: Write addresses are: 0 period shadow, 1 compare A shadow, 2 compare B shadow, 3 phase, 4 control (bit0 arm load, bit1 force trip, bit2 clear trip). Writing the shadows alone does not change the gate waveform. `wr_ready` is always 1.
- R5: After an arm write, all three shadows load together at the first zero cycle that follows. The arm then clears itself, so later shadow writes stay pending until the next arm.
- R6: A shadow write made while a load is armed replaces the pending value. The last value written before the boundary is the one loaded, and the running period is undisturbed until that boundary.
- R7: A single-cycle high on `trip_in` latches a trip. Both gates are low from the next cycle and stay low across zero events.
- R8: Setting control bit1 latches the same trip state as `trip_in`.
- R9: Setting control bit2 clears the trip, but the gates stay low until the next zero cycle and then resume normal action. A trip or force in the same cycle as a clear wins.
- R10: A `sync_in` pulse loads the phase register into the counter for the next cycle, and counting continues upward. The phase register takes effect without an arm.
- R11: After reset the counter is 0, all active and shadow values are 0, the gates are low, no trip is latched and `sync_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (constant 1) |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Register write data |
| sync_in | input | 1 | Phase load pulse |
| trip_in | input | 1 | Trip request, latched |
| sync_out | output | 1 | High while the counter is zero |
| pwm_a | output | 1 | High-side gate |
| pwm_b | output | 1 | Low-side gate |

## Verification
The bench goes after a load that lands mid-period or in pieces. Such a design would show a period length that differs from both the old and the new set, or the wrong pulse widths. It changes the shadows without an arm and after an arm has been used, which catches an arm that never clears itself or shadows that leak straight through. It programs inverted compares and a compare beyond the period, where a missing turn-on suppression shows up as both gates high in the same cycle. It also clears a trip mid-period and together with a new trip, where a design that resumes at once, or lets the clear win, would drive a gate before the next zero.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PRD   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPB  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PHASE = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;
  localparam int C_ARM   = 0;
  localparam int C_FORCE = 1;
  localparam int C_CLEAR = 2;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
endpackage

// File: rtl/hbpwm_regs.sv
module hbpwm_regs
  import hbpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              zero_i,
  output logic [W-1:0]      prd_o,
  output logic [W-1:0]      cmpa_o,
  output logic [W-1:0]      cmpb_o,
  output logic [W-1:0]      phase_o,
  output logic              force_o,
  output logic              clear_o
);
  logic [W-1:0] prd_sh, cmpa_sh, cmpb_sh;
  logic         armed_q;
  logic         ctrl_wr, arm_wr;

  assign ctrl_wr = wr_valid_i && (wr_addr_i == A_CTRL);
  assign arm_wr  = ctrl_wr && wr_data_i[C_ARM];
  assign force_o = ctrl_wr && wr_data_i[C_FORCE];
  assign clear_o = ctrl_wr && wr_data_i[C_CLEAR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_sh  <= '0;
      cmpa_sh <= '0;
      cmpb_sh <= '0;
      phase_o <= '0;
      prd_o   <= '0;
      cmpa_o  <= '0;
      cmpb_o  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_valid_i) begin
        case (wr_addr_i)
          A_PRD:   prd_sh  <= wr_data_i;
          A_CMPA:  cmpa_sh <= wr_data_i;
          A_CMPB:  cmpb_sh <= wr_data_i;
          A_PHASE: phase_o <= wr_data_i;
          default: ;
        endcase
      end
      // group transfer: all three together, once per arm
      if (zero_i && armed_q) begin
        prd_o   <= prd_sh;
        cmpa_o  <= cmpa_sh;
        cmpb_o  <= cmpb_sh;
        armed_q <= 1'b0;
      end
      if (arm_wr) armed_q <= 1'b1;
    end
  end

  // R6: working set only moves at an armed zero boundary
  p_hold_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(zero_i && armed_q) |=> ($stable(prd_o) && $stable(cmpa_o) && $stable(cmpb_o)));
  // R5: arm is consumed by the load
  p_arm_selfclear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_i && armed_q && !arm_wr) |=> !armed_q);
endmodule

// File: rtl/hbpwm_timebase.sv
module hbpwm_timebase
  import hbpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_i,
  input  logic [W-1:0] phase_i,
  input  logic [W-1:0] prd_i,
  output logic [W-1:0] cnt_o,
  output dir_e         dir_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  dir_e         dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (sync_i) begin
      cnt_q <= phase_i;
      dir_q <= DIR_UP;
    end else if (cnt_q == '0) begin
      dir_q <= DIR_UP;
      cnt_q <= (prd_i == '0) ? '0 : W'(1);
    end else if (dir_q == DIR_UP) begin
      if (cnt_q >= prd_i) begin
        dir_q <= DIR_DN;
        cnt_q <= cnt_q - W'(1);
      end else begin
        cnt_q <= cnt_q + W'(1);
      end
    end else begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign dir_o  = dir_q;
  assign zero_o = (cnt_q == '0);

  // R10: phase load on sync, then upward
  p_sync_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (cnt_q == $past(phase_i)) && (dir_q == DIR_UP));
  // R1: without sync the counter moves by one step or sits at zero
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> (cnt_q == $past(cnt_q) + W'(1)) || (cnt_q == $past(cnt_q) - W'(1))
                || (cnt_q == '0));
endmodule

// File: rtl/hbpwm_trip.sv
module hbpwm_trip (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic force_i,
  input  logic clear_i,
  input  logic zero_i,
  output logic gate_off_o
);
  logic tripped_q, resume_wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tripped_q     <= 1'b0;
      resume_wait_q <= 1'b0;
    end else if (trip_i || force_i) begin
      tripped_q <= 1'b1;
    end else if (clear_i && tripped_q) begin
      tripped_q     <= 1'b0;
      resume_wait_q <= 1'b1;
    end else if (zero_i && resume_wait_q) begin
      resume_wait_q <= 1'b0;
    end
  end

  assign gate_off_o = tripped_q || resume_wait_q;

  // R9: a trip request beats a clear in the same cycle
  p_trip_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_i || force_i) |=> tripped_q);
  // R9: leaving the hold only happens on a zero cycle
  p_resume_on_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_wait_q && !tripped_q && !zero_i) |=> gate_off_o);
endmodule

// File: rtl/hbpwm_action.sv
module hbpwm_action
  import hbpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  dir_e         dir_i,
  input  logic         zero_i,
  input  logic [W-1:0] cmpa_i,
  input  logic [W-1:0] cmpb_i,
  input  logic         gate_off_i,
  output logic         a_o,
  output logic         b_o
);
  localparam int NCH = 2;
  logic [W-1:0] on_at  [NCH];
  logic [W-1:0] off_at [NCH];
  logic         q      [NCH];

  // channel 0 acts while rising, channel 1 while falling
  assign on_at[0]  = cmpa_i;
  assign off_at[0] = cmpb_i;
  assign on_at[1]  = cmpb_i;
  assign off_at[1] = cmpa_i;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic active_dir;
    assign active_dir = (dir_i == ((i == 0) ? DIR_UP : DIR_DN));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= 1'b0;
      end else if (gate_off_i || zero_i) begin
        q[i] <= 1'b0;
      end else if (active_dir && (cnt_i == off_at[i])) begin
        q[i] <= 1'b0;
      end else if (active_dir && (cnt_i == on_at[i]) && !q[NCH-1-i]) begin
        q[i] <= 1'b1;
      end
    end
  end

  assign a_o = q[0];
  assign b_o = q[1];

  // R3: gates never on together
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(q[0] && q[1]));
  // R3: zero cycle clears both
  p_zero_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    zero_i |=> (!q[0] && !q[1]));
  // R7: trip hold clears both
  p_trip_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off_i |=> (!q[0] && !q[1]));
endmodule

// File: rtl/halfbridge_pwm.sv
module halfbridge_pwm
  import hbpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              sync_in,
  input  logic              trip_in,
  output logic              sync_out,
  output logic              pwm_a,
  output logic              pwm_b
);
  logic [W-1:0] prd, cmpa, cmpb, phase, cnt;
  dir_e         dir;
  logic         zero, force_trip, clear_trip, gate_off, a_q, b_q;

  assign wr_ready = 1'b1;

  hbpwm_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .zero_i(zero),
    .prd_o(prd), .cmpa_o(cmpa), .cmpb_o(cmpb), .phase_o(phase),
    .force_o(force_trip), .clear_o(clear_trip)
  );

  hbpwm_timebase #(.W(W)) u_tb (
    .clk(clk), .rst_n(rst_n),
    .sync_i(sync_in), .phase_i(phase), .prd_i(prd),
    .cnt_o(cnt), .dir_o(dir), .zero_o(zero)
  );

  hbpwm_trip u_trip (
    .clk(clk), .rst_n(rst_n),
    .trip_i(trip_in), .force_i(force_trip), .clear_i(clear_trip),
    .zero_i(zero), .gate_off_o(gate_off)
  );

  hbpwm_action #(.W(W)) u_act (
    .clk(clk), .rst_n(rst_n),
    .cnt_i(cnt), .dir_i(dir), .zero_i(zero),
    .cmpa_i(cmpa), .cmpb_i(cmpb), .gate_off_i(gate_off),
    .a_o(a_q), .b_o(b_q)
  );

  // trip takes the gates down in the cycle after it is latched
  assign pwm_a    = a_q && !gate_off;
  assign pwm_b    = b_q && !gate_off;
  assign sync_out = zero;
endmodule

// File: tb/halfbridge_pwm_tb.sv
module halfbridge_pwm_tb;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic sync_in = 1'b0, trip_in = 1'b0;
  logic sync_out, pwm_a, pwm_b;

  int n_chk = 0, n_err = 0;
  int m_len, m_a, m_b, m_ov;
  logic a_h [0:255];
  logic b_h [0:255];

  always #5 clk = ~clk;

  halfbridge_pwm #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .sync_in(sync_in), .trip_in(trip_in),
    .sync_out(sync_out), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [2:0] addr, input int data);
    wr_valid = 1'b1; wr_addr = addr; wr_data = W'(data);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // returns at the negedge of the next zero cycle
  task automatic goto_zero();
    while (sync_out) @(negedge clk);
    while (!sync_out) @(negedge clk);
  endtask

  // starts at a zero cycle, ends at the next one
  task automatic measure();
    int k = 0;
    m_a = 0; m_b = 0; m_ov = 0;
    do begin
      @(negedge clk);
      k++;
      if (k < 256) begin a_h[k] = pwm_a; b_h[k] = pwm_b; end
      m_a += int'(pwm_a); m_b += int'(pwm_b); m_ov += int'(pwm_a && pwm_b);
    end while (!sync_out && k < 400);
    m_len = k;
  endtask

  task automatic expect_period(input string tag, input int len, input int a, input int b);
    chk({tag, " period length"}, m_len, len);
    chk({tag, " pwm_a high cycles"}, m_a, a);
    chk({tag, " pwm_b high cycles"}, m_b, b);
    chk("R3 no overlap", m_ov, 0);
  endtask

  task automatic count_high(input int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      highs += int'(pwm_a || pwm_b);
    end
  endtask

  task automatic t_reset();
    chk("R11 pwm_a after reset", int'(pwm_a), 0);
    chk("R11 pwm_b after reset", int'(pwm_b), 0);
    chk("R11 sync_out after reset", int'(sync_out), 1);
    chk("R4 wr_ready", int'(wr_ready), 1);
  endtask

  task automatic t_basic();
    wr(3'd0, 20); wr(3'd1, 6); wr(3'd2, 14); wr(3'd4, 1);
    goto_zero();
    measure();
    expect_period("R1 R2 basic", 40, 8, 8);
    chk("R2 a low at idx6",  int'(a_h[6]), 0);
    chk("R2 a high at idx7", int'(a_h[7]), 1);
    chk("R2 a high at idx14", int'(a_h[14]), 1);
    chk("R2 a low at idx15", int'(a_h[15]), 0);
    chk("R2 b low at idx26", int'(b_h[26]), 0);
    chk("R2 b high at idx27", int'(b_h[27]), 1);
    chk("R2 b high at idx34", int'(b_h[34]), 1);
    chk("R2 b low at idx35", int'(b_h[35]), 0);
  endtask

  task automatic t_no_arm();
    wr(3'd0, 10); wr(3'd1, 2); wr(3'd2, 8);
    goto_zero();
    measure();
    expect_period("R4 shadow only", 40, 8, 8);
  endtask

  task automatic t_group();
    wr(3'd4, 1);
    goto_zero();
    measure();
    expect_period("R5 group load", 20, 6, 6);
    wr(3'd0, 30);
    goto_zero();
    measure();
    expect_period("R5 arm self-clear", 20, 6, 6);
  endtask

  task automatic t_pending();
    fork
      measure();
      begin wr(3'd0, 24); wr(3'd4, 1); wr(3'd0, 16); end
    join
    expect_period("R6 active undisturbed", 20, 6, 6);
    measure();
    expect_period("R6 last pending value", 32, 6, 6);
  endtask

  task automatic t_fault();
    fork
      measure();
      begin wr(3'd1, 14); wr(3'd2, 6); wr(3'd0, 20); wr(3'd4, 1); end
    join
    measure();
    expect_period("R3 inverted compares", 40, 26, 0);
    fork
      measure();
      begin wr(3'd1, 6); wr(3'd2, 30); wr(3'd4, 1); end
    join
    measure();
    expect_period("R3 compare B beyond period", 40, 34, 0);
  endtask

  task automatic t_trip();
    int h;
    fork
      measure();
      begin wr(3'd1, 6); wr(3'd2, 14); wr(3'd4, 1); end
    join
    measure();
    expect_period("R2 restored", 40, 8, 8);
    repeat (10) @(negedge clk);
    chk("R7 pwm_a high before trip", int'(pwm_a), 1);
    trip_in = 1'b1;
    @(negedge clk);
    trip_in = 1'b0;
    chk("R7 pwm_a low after trip", int'(pwm_a), 0);
    count_high(60, h);
    chk("R7 gates held low across zero", h, 0);
    wr(3'd4, 4);
    h = 0;
    while (!sync_out) begin
      h += int'(pwm_a || pwm_b);
      @(negedge clk);
    end
    chk("R9 gates low until zero after clear", h, 0);
    measure();
    expect_period("R9 resume after clear", 40, 8, 8);
  endtask

  task automatic t_force();
    int h;
    repeat (10) @(negedge clk);
    wr(3'd4, 2);
    chk("R8 pwm_a low after force", int'(pwm_a), 0);
    trip_in = 1'b1;
    wr(3'd4, 4);
    trip_in = 1'b0;
    count_high(50, h);
    chk("R9 trip beats clear", h, 0);
    wr(3'd4, 4);
    goto_zero();
    measure();
    expect_period("R8 resume after force", 40, 8, 8);
  endtask

  task automatic t_sync();
    int k = 0;
    wr(3'd3, 10);
    goto_zero();
    repeat (25) @(negedge clk);
    sync_in = 1'b1;
    do begin
      @(negedge clk);
      k++;
      sync_in = 1'b0;
    end while (!sync_out && k < 200);
    chk("R10 cycles from sync to zero", k, 31);
    measure();
    expect_period("R10 period after sync", 40, 8, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_no_arm();
    t_group();
    t_pending();
    t_fault();
    t_trip();
    t_force();
    t_sync();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end
endmodule